// File: doc/BRIEF.md
# Gated Synchronous Power-of-Two Clock Divider

This block takes one input clock and derives three square-wave outputs from it, at one half, one quarter and one eighth of the input frequency. All three come from a single synchronous counter chain clocked by the input clock, so every output changes on a rising input edge. Wherever two or three outputs change together, they change on the same edge.

A single active-high enable starts and stops all three dividers together. The enable is captured on the falling input edge. A rising edge advances the chain only if the value captured half a cycle earlier was high. The chain's clock can therefore only start or stop while the input clock is low, and no stage ever sees a shortened pulse. A master reset clears every stage at once, without waiting for a clock edge. Releasing reset on several instances at the same time brings them into the same phase.

Top module: `clkdiv_pow2`

## Requirements
- R1: While `masterRst` is high, all three outputs are low. Asserting it clears them at once, without waiting for a clock edge.
- R2: `enableIn` is sampled on each falling edge of `clkIn`. A rising edge is an advancing edge only if the value sampled at the falling edge just before it was 1. A level that `enableIn` holds only between a falling edge and the following rising edge has no effect on the outputs.
- R3: After reset, the first advancing edge drives all three outputs from 0 to 1 on that same edge.
- R4: `outDiv2` inverts on every advancing edge, so with enable held high its period is 2 input periods.
- R5: The vector {outDiv8,outDiv4,outDiv2} (bit 2 = outDiv8, bit 0 = outDiv2) decreases by one on every advancing edge, modulo 8, wrapping from 000 to 111. With enable held high, outDiv4 therefore has a period of 4 input periods and outDiv8 a period of 8 input periods.
- R6: A rising edge that is not an advancing edge leaves all three outputs unchanged.
- R7: A disable period never skips or repeats a count. At any time, the vector equals minus the number of advancing edges since reset, modulo 8.
- R8: Outputs change only on rising input edges. No output ever holds a level for less than one input period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock to be divided |
| masterRst | input | 1 | Asynchronous active-high reset of all divider stages and of the enable capture |
| enableIn | input | 1 | Active-high run enable, sampled on the falling edge of clkIn |
| outDiv2 | output | 1 | Input clock divided by 2 |
| outDiv4 | output | 1 | Input clock divided by 4 |
| outDiv8 | output | 1 | Input clock divided by 8 |

## Verification
The properties assume that `enableIn` is stable around each falling edge of `clkIn`. They also assume that a change of `masterRst` does not coincide with a rising clock edge, since any fresh count relation is only claimed after reset has been low for a full edge. The stimulus drives every input change at fixed offsets from the rising edge: 1 to 6 ns after it, in a 10 ns period. Each change therefore lands well away from both clock edges. Random enable patterns come from a deterministic shift register, so the expected count can be derived one edge at a time.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // Number of divider stages (divide by 2, 4, 8).
  localparam int DIV_STAGES = 3;

  // Strobes passed from the enable control to the counter chain.
  typedef struct packed {
    logic advance;   // this rising edge moves the chain by one count
  } ctrlStrobes_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic         clkIn,
  input  logic         masterRst,
  input  logic         enableIn,
  output ctrlStrobes_t strobes
);
  logic enCaptured;

  // Enable captured on the falling edge, so the effective gate only
  // opens or closes during the low phase of the input clock.
  always_ff @(negedge clkIn or posedge masterRst) begin
    if (masterRst) enCaptured <= 1'b0;
    else           enCaptured <= enableIn;
  end

  always_comb begin
    strobes = '0;
    strobes.advance = enCaptured;
  end
endmodule

// File: rtl/clkdiv_chain.sv
`timescale 1ns/1ps
module clkdiv_chain
  import clkdiv_pkg::*;
#(
  parameter int STAGES = DIV_STAGES
) (
  input  logic              clkIn,
  input  logic              masterRst,
  input  ctrlStrobes_t      strobes,
  output logic [STAGES-1:0] stageQ
);
  logic [STAGES-1:0] toggleEn;

  // Down counter built from toggle stages: stage s flips when all
  // lower stages are zero, so every stage flips on the wrap to all ones.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic bitQ;
    if (s == 0) begin : g_first
      assign toggleEn[s] = strobes.advance;
    end else begin : g_upper
      assign toggleEn[s] = strobes.advance && (stageQ[s-1:0] == '0);
    end

    always_ff @(posedge clkIn or posedge masterRst) begin
      if (masterRst)        bitQ <= 1'b0;
      else if (toggleEn[s]) bitQ <= ~bitQ;
    end

    assign stageQ[s] = bitQ;
  end
endmodule

// File: rtl/clkdiv_pow2.sv
`timescale 1ns/1ps
module clkdiv_pow2
  import clkdiv_pkg::*;
(
  input  logic clkIn,
  input  logic masterRst,
  input  logic enableIn,
  output logic outDiv2,
  output logic outDiv4,
  output logic outDiv8
);
  ctrlStrobes_t            strobes;
  logic [DIV_STAGES-1:0]   stageQ;

  clkdiv_ctrl i_ctrl (
    .clkIn     (clkIn),
    .masterRst (masterRst),
    .enableIn  (enableIn),
    .strobes   (strobes)
  );

  clkdiv_chain #(.STAGES(DIV_STAGES)) i_chain (
    .clkIn     (clkIn),
    .masterRst (masterRst),
    .strobes   (strobes),
    .stageQ    (stageQ)
  );

  assign outDiv2 = stageQ[0];
  assign outDiv4 = stageQ[1];
  assign outDiv8 = stageQ[2];
endmodule

// File: rtl/clkdiv_pow2_chk.sv
`timescale 1ns/1ps
module clkdiv_pow2_chk (
  input logic       clkIn,
  input logic       masterRst,
  input logic       advance,
  input logic [2:0] outs
);
  logic [2:0] fallSnap;

  always_ff @(negedge clkIn or posedge masterRst) begin
    if (masterRst) fallSnap <= '0;
    else           fallSnap <= outs;
  end

  always @(posedge clkIn) begin
    if (masterRst) begin
      AST_RESET_LOW: assert (outs == 3'b000) else $error("outputs not low in reset"); // R1
    end
  end

  AST_ALL_RISE_ON_WRAP: assert property (@(posedge clkIn) disable iff (masterRst)
    (advance && outs == 3'b000) |=> (outs == 3'b111)) else $error("wrap not common rise"); // R3

  AST_DIV2_FLIPS: assert property (@(posedge clkIn) disable iff (masterRst)
    advance |=> (outs[0] != $past(outs[0]))) else $error("div2 did not flip"); // R4

  AST_COUNT_DOWN: assert property (@(posedge clkIn) disable iff (masterRst)
    advance |=> (outs == $past(outs) - 3'd1)) else $error("count step wrong"); // R5

  AST_HOLD_WHEN_OFF: assert property (@(posedge clkIn) disable iff (masterRst)
    !advance |=> $stable(outs)) else $error("outputs moved while disabled"); // R6

  AST_NO_LOW_PHASE_CHANGE: assert property (@(posedge clkIn) disable iff (masterRst)
    outs == fallSnap) else $error("output changed in low phase"); // R8
endmodule

bind clkdiv_pow2 clkdiv_pow2_chk i_chk (
  .clkIn     (clkIn),
  .masterRst (masterRst),
  .advance   (strobes.advance),
  .outs      ({outDiv8, outDiv4, outDiv2})
);

// File: tb/test_clkdiv_pow2.sv
`timescale 1ns/1ps
module test_clkdiv_pow2;
  logic clkIn = 1'b0;
  logic masterRst = 1'b1;
  logic enableIn = 1'b0;
  logic outDiv2, outDiv4, outDiv8;
  logic [2:0] outs;
  int checks = 0;
  int errors = 0;
  logic [2:0] expState = 3'b000;
  bit runtWatch = 1'b0;
  int runtCount = 0;
  realtime lastChg2 = 0.0, lastChg4 = 0.0, lastChg8 = 0.0;

  assign outs = {outDiv8, outDiv4, outDiv2};

  clkdiv_pow2 i_clkdiv_pow2 (
    .clkIn(clkIn), .masterRst(masterRst), .enableIn(enableIn),
    .outDiv2(outDiv2), .outDiv4(outDiv4), .outDiv8(outDiv8)
  );

  always #5 clkIn = ~clkIn;

  // Runt monitor: every level must last at least one 10 ns input period.
  always @(outDiv2) begin
    if (runtWatch && ($realtime - lastChg2) < 10.0) runtCount++;
    lastChg2 = $realtime;
  end
  always @(outDiv4) begin
    if (runtWatch && ($realtime - lastChg4) < 10.0) runtCount++;
    lastChg4 = $realtime;
  end
  always @(outDiv8) begin
    if (runtWatch && ($realtime - lastChg8) < 10.0) runtCount++;
    lastChg8 = $realtime;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Convention: every task starts and ends 3 ns after a rising edge.
  task automatic doReset();
    masterRst = 1'b1;
    #1;
    check(outs == 3'b000, "R1", "immediate clear", outs, 0);
    repeat (3) begin
      @(posedge clkIn); #2;
      check(outs == 3'b000, "R1", "held low in reset", outs, 0);
      #1;
    end
    masterRst = 1'b0;
    enableIn = 1'b0;
    expState = 3'b000;
    @(posedge clkIn); #2;
    check(outs == 3'b000, "R2", "idle after reset", outs, 0);
    #1;
  endtask

  task automatic testFirstRise();
    enableIn = 1'b1;
    @(posedge clkIn); #2;
    expState = 3'b111;
    check(outs == 3'b111, "R3", "first edge common rise", outs, 7);
    #1;
  endtask

  task automatic testPeriods();
    int lastRise [3] = '{-1, -1, -1};
    logic [2:0] prev = outs;
    enableIn = 1'b1;
    for (int cyc = 0; cyc < 24; cyc++) begin
      @(posedge clkIn); #2;
      expState = expState - 3'd1;
      check(outs == expState, "R5", "down count", outs, expState);
      check(outs[0] != prev[0], "R4", "div2 flips", outs[0], !prev[0]);
      for (int b = 0; b < 3; b++) begin
        if (!prev[b] && outs[b]) begin
          if (lastRise[b] >= 0)
            check(cyc - lastRise[b] == (2 << b), "R5", "rise period",
                  cyc - lastRise[b], 2 << b);
          lastRise[b] = cyc;
        end
      end
      prev = outs;
      #1;
    end
  endtask

  task automatic testHoldResume();
    logic [2:0] snap = outs;
    enableIn = 1'b0;
    for (int cyc = 0; cyc < 6; cyc++) begin
      @(posedge clkIn); #2;
      check(outs == snap, "R6", "hold while disabled", outs, snap);
      #1;
    end
    enableIn = 1'b1;
    for (int cyc = 0; cyc < 8; cyc++) begin
      @(posedge clkIn); #2;
      expState = expState - 3'd1;
      check(outs == expState, "R7", "resume without slip", outs, expState);
      #1;
    end
  endtask

  task automatic testEnableEdge();
    enableIn = 1'b0;
    @(posedge clkIn); #2;
    check(outs == expState, "R6", "settle disabled", outs, expState);
    #1;
    // Pattern A: high only across the falling edge -> exactly one advance.
    enableIn = 1'b1;
    #3 enableIn = 1'b0;
    @(posedge clkIn); #2;
    expState = expState - 3'd1;
    check(outs == expState, "R2", "falling-edge sample advances", outs, expState);
    @(posedge clkIn); #2;
    check(outs == expState, "R2", "single advance only", outs, expState);
    // Pattern B: high only from after falling edge to after rising edge.
    #4 enableIn = 1'b1;
    @(posedge clkIn); #1 enableIn = 1'b0;
    #1;
    check(outs == expState, "R2", "pulse missing fall ignored", outs, expState);
    @(posedge clkIn); #2;
    check(outs == expState, "R2", "pulse still ignored", outs, expState);
    #1;
  endtask

  task automatic testRandomEnable();
    logic [15:0] lfsr = 16'hACE1;
    runtWatch = 1'b1;
    for (int cyc = 0; cyc < 300; cyc++) begin
      logic bitEn;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bitEn = lfsr[0] | lfsr[3];
      enableIn = bitEn;
      @(posedge clkIn); #2;
      if (bitEn) expState = expState - 3'd1;
      check(outs == expState, "R7", "random enable count", outs, expState);
      #1;
    end
    runtWatch = 1'b0;
    check(runtCount == 0, "R8", "no short output level", runtCount, 0);
  endtask

  initial begin
    repeat (2) @(posedge clkIn);
    #3;
    doReset();
    testFirstRise();
    testPeriods();
    testHoldResume();
    testEnableEdge();
    testRandomEnable();
    enableIn = 1'b1;
    repeat (3) begin @(posedge clkIn); #3; end
    doReset();          // mid-run asynchronous clear
    testFirstRise();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clkIn);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule